// File: doc/BRIEF.md
# Text-Mode Screen Address Generator

This block produces the screen-memory address for a character-cell display. Every clock is one character period. A linear address counter moves forward by one only while the visible-cell input is high. It does not move during horizontal or vertical blanking. The generator also keeps the address where the current character row begins. Each of the eight pixel lines that make up that row starts again from this address, so the same 40 cells are fetched eight times. After the eighth line, the saved start moves to the first cell of the next row. That cell is the value the counter has already reached.

A three-bit pixel-line index is output alongside the address, for use by the glyph lookup that follows. After 25 rows (200 lines, 1000 cells), the block enters a halted state. In that state the address and line index stay frozen until the next end-of-frame strobe, even if more active lines arrive. The block has two states. `ST_SCAN` is the normal scanning state. `ST_HALT` means the frame's rows are used up. There are two transitions: `ST_SCAN` to `ST_HALT` on the line end of the last line of the last row, and any state to `ST_SCAN` on a frame end.

Top module: `text_addr_gen`

## Requirements
- R1: While `rst_n` is low, `scr_addr` is 0 and `scan_line` is 0.
- R2: In `ST_SCAN`, a clock with `vis_en` high and both strobes low makes `scr_addr` one greater on the next clock.
- R3: A clock with `vis_en`, `line_end` and `frame_end` all low leaves `scr_addr` and `scan_line` unchanged.
- R4: In `ST_SCAN`, a `line_end` on pixel lines 0 to 6 loads `scr_addr` with the saved row start and increments `scan_line`.
- R5: In `ST_SCAN` on rows 0 to 23, a `line_end` on pixel line 7 copies `scr_addr` into the saved row start, keeps `scr_addr`, and returns `scan_line` to 0. The next row therefore begins 40 cells after the previous one.
- R6: `frame_end` has top priority. On the next clock, `scr_addr`, the saved row start, `scan_line` and the row count are all 0, and the state is `ST_SCAN`.
- R7: When `line_end` and `vis_en` are high together, only the line-end action takes place.
- R8: `scr_addr` never goes above 999. A visible clock at 999 leaves it at 999.
- R9: A `line_end` on pixel line 7 of row 24 enters `ST_HALT`. There, `vis_en` and `line_end` are ignored, and `scr_addr` stays at 999 and `scan_line` at 7 until `frame_end`.
- R10: In a frame of 25 rows × 8 lines × 40 visible cells, line l of row r presents addresses r·40 to r·40+39 in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vis_en | input | 1 | High on visible character positions |
| line_end | input | 1 | One-clock strobe at the end of each pixel line |
| frame_end | input | 1 | One-clock strobe at the end of each frame |
| scr_addr | output | 10 | Screen memory address |
| scan_line | output | 3 | Pixel line within the current character row |

## Verification
A corrupted saved row start does not show while a line is being drawn. It shows at the first address after the next line end, so at most one pixel line later. A line count that is off by one is visible on `scan_line` at once. It also moves every later row start by 40 cells, and it makes the halt arrive one line early or late. The bench computes the address and line index for every clock from a plain behavioural model and compares them on every cycle. A fault therefore surfaces in the cycle in which it first reaches a port.

// File: rtl/text_addr_pkg.sv
package text_addr_pkg;

    // Scanning state of the address generator
    typedef enum logic [0:0] {
        ST_SCAN = 1'b0,   // rows still to be drawn
        ST_HALT = 1'b1    // all rows drawn, outputs frozen until frame end
    } scan_state_t;

endpackage

// File: rtl/tag_addr_ctr.sv
module tag_addr_ctr #(
    parameter int AW   = 10,
    parameter int LAST = 999
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          reload,
    input  logic          step,
    input  logic [AW-1:0] reload_val,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] LAST_V = AW'(LAST);

    logic at_top;
    assign at_top = (addr == LAST_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (clr) begin
            addr <= '0;
        end else if (reload) begin
            addr <= reload_val;
        end else if (step && !at_top) begin
            addr <= addr + 1'b1;
        end
    end

    AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && !reload && !at_top) |=> (addr == $past(addr) + 1'b1)); // R2

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && !reload && at_top) |=> (addr == LAST_V)); // R8

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (addr == '0)); // R6

endmodule

// File: rtl/tag_row_latch.sv
module tag_row_latch #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          capture,
    input  logic [AW-1:0] d,
    output logic [AW-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (capture) begin
            q <= d;
        end
    end

    AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !capture) |=> $stable(q)); // R5

    AST_LATCH_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && capture) |=> (q == $past(d))); // R5

endmodule

// File: rtl/tag_line_ctr.sv
module tag_line_ctr #(
    parameter int LINES = 8,
    parameter int ROWS  = 25,
    parameter int LW    = 3,
    parameter int RW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [LW-1:0] line,
    output logic          last_line,
    output logic          last_row
);

    localparam logic [LW-1:0] LINE_TOP = LW'(LINES - 1);
    localparam logic [RW-1:0] ROW_TOP  = RW'(ROWS - 1);

    logic [RW-1:0] row;

    assign last_line = (line == LINE_TOP);
    assign last_row  = (row == ROW_TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line <= '0;
            row  <= '0;
        end else if (clr) begin
            line <= '0;
            row  <= '0;
        end else if (adv) begin
            if (last_line) begin
                line <= '0;
                row  <= row + 1'b1;
            end else begin
                line <= line + 1'b1;
            end
        end
    end

    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && last_line) |=> (line == '0)); // R5

    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && !last_line) |=> (line == $past(line) + 1'b1)); // R4

endmodule

// File: rtl/text_addr_gen.sv
module text_addr_gen #(
    parameter int COLS  = 40,
    parameter int ROWS  = 25,
    parameter int LINES = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              vis_en,
    input  logic                              line_end,
    input  logic                              frame_end,
    output logic [$clog2(COLS*ROWS)-1:0]      scr_addr,
    output logic [$clog2(LINES)-1:0]          scan_line
);

    import text_addr_pkg::*;

    localparam int CELLS = COLS * ROWS;
    localparam int AW    = $clog2(CELLS);
    localparam int LW    = $clog2(LINES);
    localparam int RW    = $clog2(ROWS);
    localparam logic [AW-1:0] LAST_V = AW'(CELLS - 1);

    scan_state_t state_q, state_d;

    logic          do_clr, do_reload, do_step, do_capture, do_line_adv;
    logic          last_line, last_row;
    logic [AW-1:0] row_start;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SCAN: begin
                if (frame_end) begin
                    state_d = ST_SCAN;
                end else if (line_end && last_line && last_row) begin
                    state_d = ST_HALT;
                end
            end
            ST_HALT: begin
                if (frame_end) begin
                    state_d = ST_SCAN;
                end
            end
            default: state_d = ST_SCAN;
        endcase
    end

    // Output controls, priority frame_end > line_end > vis_en
    always_comb begin
        do_clr      = frame_end;
        do_reload   = 1'b0;
        do_step     = 1'b0;
        do_capture  = 1'b0;
        do_line_adv = 1'b0;
        unique case (state_q)
            ST_SCAN: begin
                if (!frame_end) begin
                    if (line_end) begin
                        if (!last_line) begin
                            do_reload   = 1'b1;
                            do_line_adv = 1'b1;
                        end else if (!last_row) begin
                            do_capture  = 1'b1;
                            do_line_adv = 1'b1;
                        end
                    end else if (vis_en) begin
                        do_step = 1'b1;
                    end
                end
            end
            ST_HALT: begin
                do_reload = 1'b0;
            end
            default: do_reload = 1'b0;
        endcase
    end

    tag_addr_ctr #(
        .AW   (AW),
        .LAST (CELLS - 1)
    ) addr_ctr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (do_clr),
        .reload     (do_reload),
        .step       (do_step),
        .reload_val (row_start),
        .addr       (scr_addr)
    );

    tag_row_latch #(
        .AW (AW)
    ) row_latch_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (do_clr),
        .capture (do_capture),
        .d       (scr_addr),
        .q       (row_start)
    );

    tag_line_ctr #(
        .LINES (LINES),
        .ROWS  (ROWS),
        .LW    (LW),
        .RW    (RW)
    ) line_ctr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (do_clr),
        .adv       (do_line_adv),
        .line      (scan_line),
        .last_line (last_line),
        .last_row  (last_row)
    );

    AST_ADDR_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        scr_addr <= LAST_V); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!vis_en && !line_end && !frame_end) |=> ($stable(scr_addr) && $stable(scan_line))); // R3

    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && !frame_end && line_end && !last_line) |=> (scr_addr == $past(row_start))); // R4

    AST_EOL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && !frame_end && line_end && vis_en && last_line && !last_row) |=> $stable(scr_addr)); // R7

    AST_FRAME_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (scr_addr == '0 && scan_line == '0 && state_q == ST_SCAN)); // R6

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !frame_end) |=> ($stable(scr_addr) && $stable(scan_line))); // R9

endmodule

// File: tb/text_addr_gen_tb.sv
`timescale 1ns/1ps
module text_addr_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vis_en = 1'b0;
    logic       line_end = 1'b0;
    logic       frame_end = 1'b0;
    logic [9:0] scr_addr;
    logic [2:0] scan_line;

    int n_tests = 0;
    int n_fail  = 0;

    // behavioural reference state
    int m_addr = 0, m_start = 0, m_line = 0, m_row = 0;
    bit m_halt = 0;

    always #2 clk = ~clk;

    text_addr_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .vis_en    (vis_en),
        .line_end  (line_end),
        .frame_end (frame_end),
        .scr_addr  (scr_addr),
        .scan_line (scan_line)
    );

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(bit d, bit e, bit f);
        if (f) begin
            m_addr = 0; m_start = 0; m_line = 0; m_row = 0; m_halt = 0;
        end else if (!m_halt) begin
            if (e) begin
                if (m_line == 7) begin
                    if (m_row == 24) m_halt = 1;
                    else begin
                        m_start = m_addr; m_line = 0; m_row++;
                    end
                end else begin
                    m_line++; m_addr = m_start;
                end
            end else if (d) begin
                if (m_addr < 999) m_addr++;
            end
        end
    endtask

    // compare current outputs, apply inputs for one clock, advance model
    task automatic tick(bit d, bit e, bit f, string tag);
        @(negedge clk);
        chk({tag, " addr"}, int'(scr_addr), m_addr);
        chk({tag, " line"}, int'(scan_line), m_line);
        vis_en = d; line_end = e; frame_end = f;
        @(posedge clk);
        model_step(d, e, f);
    endtask

    // explicit check shortly after the edge that produced the state
    task automatic peek(string tag, int exp_addr, int exp_line);
        #1;
        chk({tag, " addr"}, int'(scr_addr), exp_addr);
        chk({tag, " line"}, int'(scan_line), exp_line);
    endtask

    task automatic run_line(int width, string tag);
        repeat (width) tick(1, 0, 0, tag);
        repeat (3) tick(0, 0, 0, "R3");
        tick(0, 1, 0, tag);
        repeat (2) tick(0, 0, 0, "R3");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        peek("R1", 0, 0);
        @(negedge clk);
        rst_n = 1'b1;

        tick(0, 0, 1, "R6");

        // full well-formed frame
        for (int r = 0; r < 25; r++) begin
            for (int l = 0; l < 8; l++) begin
                peek((l == 0 && r > 0) ? "R5" : "R10", r * 40, l);
                run_line(40, "R2");
            end
        end
        peek("R9", 999, 7);
        for (int k = 0; k < 3; k++) run_line(40, "R9");
        peek("R9", 999, 7);

        // frame end wins over everything and leaves halt
        tick(1, 1, 1, "R6");
        peek("R6", 0, 0);

        // line end together with visible flag
        repeat (5) tick(1, 0, 0, "R2");
        tick(1, 1, 0, "R7");
        peek("R7", 0, 1);

        // restart and reach the last row, then overrun the line
        tick(0, 0, 1, "R6");
        for (int k = 0; k < 192; k++) run_line(40, "R10");
        peek("R5", 960, 0);
        repeat (45) tick(1, 0, 0, "R8");
        peek("R8", 999, 0);
        tick(0, 1, 0, "R4");
        peek("R4", 960, 1);

        // mid-frame frame end
        repeat (7) tick(1, 0, 0, "R2");
        tick(0, 0, 1, "R6");
        peek("R6", 0, 0);
        tick(0, 0, 0, "R3");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule